// File: doc/BRIEF.md
# Fractional Divide Accumulator with Half-LSB Dither

This block supplies the fractional part of a synthesizer's divide ratio. On every comparison-clock tick it adds a fractional word to a running accumulator and, whenever that sum wraps, it raises a one-cycle increment request. The main divider uses that request to divide by one extra count for that cycle. Over many ticks the average increment rate equals the fraction `fracWord / 2^FRAC_W`.

A select input switches on an extra bit below the least-significant bit of the word, held at a constant 1. The accumulator is then effectively `FRAC_W+1` bits wide and adds `{fracWord, 1}` on each tick. This breaks up the short repeating carry patterns that produce spurious tones. The cost is a small, fixed rise in the average fraction of `1 / 2^(FRAC_W+1)`, which is a positive offset of `fc / 2^(FRAC_W+1)` at comparison frequency `fc`. When the divider runs in integer-only mode, the surrounding logic simply holds `tickEn` low.

Top module: `frac_dither_accum`

## Requirements
- R1: An asynchronous active-low reset clears the accumulator to zero. `carryOut` is low while reset is held and in the first cycle after it.
- R2: The accumulator is `FRAC_W+1` bits wide. `fracWord` occupies its upper `FRAC_W` bits and the dither bit occupies bit 0. On each rising clock edge with `tickEn` high, it adds `{fracWord, ditherSel}` modulo `2^(FRAC_W+1)`.
- R3: `carryOut` is registered. In the cycle after a clock edge with `tickEn` high, it is high exactly when that addition wrapped past `2^(FRAC_W+1)`. After an edge with `tickEn` low, `carryOut` is low and the accumulator holds its value.
- R4: With `ditherSel` low and a constant word K, any `2^FRAC_W` consecutive ticks produce exactly K carries.
- R5: With `fracWord` = 0 and `ditherSel` low, `carryOut` never rises.
- R6: With `ditherSel` high and a constant word K, any `2^(FRAC_W+1)` consecutive ticks produce exactly `2K+1` carries. This is the half-LSB positive offset.
- R7: With the full-scale word `2^FRAC_W - 1`, `ditherSel` low, and the accumulator starting from zero, the first tick gives no carry and each of the following ticks, up to tick `2^FRAC_W`, gives a carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fracWord | input | FRAC_W | Fractional word K |
| ditherSel | input | 1 | Enables the constant half-LSB bit |
| tickEn | input | 1 | Advances the accumulator on this edge |
| carryOut | output | 1 | One-cycle increment request to the main divider |

## Verification
Only one register lies between the inputs and `carryOut`. The wrap caused by the inputs present at a rising edge is therefore visible from that edge until the next one. The bench drives inputs and samples the output on falling edges, and compares `carryOut` against a behavioural integer model on every cycle. A tick's result is due one half-period after the edge that consumes it. The window counts for R4, R6 and R7 use the same sampling points, so each counted sample belongs to exactly one tick. A narrow second instance makes the dither window short enough to cover completely.

// File: rtl/fracacc_pkg.sv
package fracacc_pkg;
  typedef struct packed {
    logic addStep;
    logic halfLsb;
  } accCtrl_t;
endpackage

// File: rtl/fracacc_ctrl.sv
module fracacc_ctrl
  import fracacc_pkg::*;
#(
  parameter bit DITHER_EN = 1'b1
) (
  input  logic     tickEn,
  input  logic     ditherSel,
  output accCtrl_t ctrl
);
  generate
    if (DITHER_EN) begin : g_dither
      always_comb begin
        ctrl.addStep = tickEn;
        ctrl.halfLsb = ditherSel;
      end
    end else begin : g_noDither
      always_comb begin
        ctrl.addStep = tickEn;
        ctrl.halfLsb = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/fracacc_dp.sv
module fracacc_dp
  import fracacc_pkg::*;
#(
  parameter int FRAC_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FRAC_W-1:0] fracWord,
  input  accCtrl_t          ctrl,
  output logic              carryOut,
  output logic [FRAC_W:0]   accState
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] accReg;
  logic [ACC_W:0]   sumWide;

  always_comb begin
    sumWide = {1'b0, accReg} + {1'b0, fracWord, ctrl.halfLsb};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      carryOut <= 1'b0;
    end else if (ctrl.addStep) begin
      accReg   <= sumWide[ACC_W-1:0];
      carryOut <= sumWide[ACC_W];
    end else begin
      carryOut <= 1'b0;
    end
  end

  assign accState = accReg;
endmodule

// File: rtl/frac_dither_accum.sv
module frac_dither_accum
  import fracacc_pkg::*;
#(
  parameter int FRAC_W    = 18,
  parameter bit DITHER_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FRAC_W-1:0] fracWord,
  input  logic              ditherSel,
  input  logic              tickEn,
  output logic              carryOut
);
  accCtrl_t        ctrlBus;
  logic [FRAC_W:0] accState;

  fracacc_ctrl #(.DITHER_EN(DITHER_EN)) u_ctrl (
    .tickEn   (tickEn),
    .ditherSel(ditherSel),
    .ctrl     (ctrlBus)
  );

  fracacc_dp #(.FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .fracWord(fracWord),
    .ctrl    (ctrlBus),
    .carryOut(carryOut),
    .accState(accState)
  );
endmodule

// File: rtl/frac_dither_accum_chk.sv
module frac_dither_accum_chk #(
  parameter int FRAC_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic [FRAC_W-1:0] fracWord,
  input logic              ditherSel,
  input logic              tickEn,
  input logic              carryOut,
  input logic [FRAC_W:0]   accState
);
  // R1: while reset is held, the next sample of the carry is low
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> !carryOut);

  // R3: an idle edge drops the carry and freezes the accumulator
  a_r3_idle_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> (!carryOut && $stable(accState)));

  // R3: a carry means the accumulator wrapped to a smaller value
  a_r3_carry_is_wrap: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |-> (accState < $past(accState)));

  // R2: a tick without a carry never moves the accumulator down
  a_r2_no_wrap_grows: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tickEn) && !carryOut) |-> (accState >= $past(accState)));

  // R5: a zero word without dither cannot wrap
  a_r5_zero_word: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && fracWord == '0 && !ditherSel) |=> !carryOut);
endmodule

bind frac_dither_accum frac_dither_accum_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fracWord (fracWord),
  .ditherSel(ditherSel),
  .tickEn   (tickEn),
  .carryOut (carryOut),
  .accState (accState)
);

// File: tb/frac_dither_accum_tb.sv
`timescale 1ns/1ps
module frac_dither_accum_tb;
  localparam int BW = 18;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [BW-1:0] bigWord = '0;
  logic bigSel = 1'b0, bigEn = 1'b0, bigCarry;
  logic [SW-1:0] smWord = '0;
  logic smSel = 1'b0, smEn = 1'b0, smCarry;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_dither_accum #(.FRAC_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .fracWord(bigWord), .ditherSel(bigSel),
    .tickEn(bigEn), .carryOut(bigCarry));

  frac_dither_accum #(.FRAC_W(SW)) u_small (
    .clk(clk), .rstN(rstN), .fracWord(smWord), .ditherSel(smSel),
    .tickEn(smEn), .carryOut(smCarry));

  // behavioural reference models
  longint bigAcc = 0, smAcc = 0;
  bit bigExp = 1'b0, smExp = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bigAcc = 0; smAcc = 0; bigExp = 1'b0; smExp = 1'b0;
    end else begin
      if (bigEn) begin
        longint s;
        s = bigAcc + 2 * longint'(bigWord) + longint'(bigSel);
        bigExp = (s >= (longint'(1) << (BW + 1)));
        bigAcc = s % (longint'(1) << (BW + 1));
      end else bigExp = 1'b0;
      if (smEn) begin
        longint s;
        s = smAcc + 2 * longint'(smWord) + longint'(smSel);
        smExp = (s >= (longint'(1) << (SW + 1)));
        smAcc = s % (longint'(1) << (SW + 1));
      end else smExp = 1'b0;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, R2 and R3
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2/R3 big", bigCarry, bigExp);
      check("R2/R3 small", smCarry, smExp);
    end
  end

  task automatic runBig(input int n, input logic [BW-1:0] w, input logic s, output int cnt);
    cnt = 0;
    bigWord = w; bigSel = s; bigEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt += int'(bigCarry);
    end
    bigEn = 1'b0;
  endtask

  task automatic runSmall(input int n, input logic [SW-1:0] w, input logic s, output int cnt);
    cnt = 0;
    smWord = w; smSel = s; smEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt += int'(smCarry);
    end
    smEn = 1'b0;
  endtask

  task automatic report();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    int cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        report();
      end
    end
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    check("R1 big carry in reset", bigCarry, 0);
    check("R1 small carry in reset", smCarry, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 big after reset", bigCarry, 0);

    // R5: zero word never carries
    runBig(60, '0, 1'b0, cnt);
    check("R5 zero word carries", cnt, 0);

    // R7: full scale from zero, first tick silent then every tick
    bigEn = 1'b0; bigWord = {BW{1'b1}}; bigSel = 1'b0;
    bigEn = 1'b1;
    @(negedge clk);
    check("R7 first tick", bigCarry, 0);
    runBig(40, {BW{1'b1}}, 1'b0, cnt);
    check("R7 following ticks", cnt, 40);

    // R3: idle cycles, carry low and state held (model compares)
    repeat (6) @(negedge clk);
    check("R3 idle carry", bigCarry, 0);

    // R2: assorted words and dither, compared each cycle by the model
    runBig(50, 18'h2AAAB, 1'b0, cnt);
    runBig(50, 18'h3F001, 1'b1, cnt);
    runBig(30, 18'h20000, 1'b1, cnt);
    for (int i = 0; i < 40; i++) begin
      bigWord = BW'((i * 40503 + 977) & ((1 << BW) - 1));
      bigSel = i[0];
      bigEn = (i % 5) != 3;
      @(negedge clk);
    end
    bigEn = 1'b0;

    // R4: no dither, 2^SW ticks give K carries
    runSmall(16, 4'd5, 1'b0, cnt);
    check("R4 K=5 window", cnt, 5);
    runSmall(16, 4'd11, 1'b0, cnt);
    check("R4 K=11 window", cnt, 11);

    // R6: dither, 2^(SW+1) ticks give 2K+1 carries
    runSmall(32, 4'd0, 1'b1, cnt);
    check("R6 K=0 window", cnt, 1);
    runSmall(32, 4'd8, 1'b1, cnt);
    check("R6 K=8 window", cnt, 17);
    runSmall(32, 4'd3, 1'b1, cnt);
    check("R6 K=3 window", cnt, 7);

    // R1: reset mid-run clears the state
    smWord = 4'd15; smEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 small after reset", smCarry, 0);
    smEn = 1'b0; rstN = 1'b1;
    runSmall(1, 4'd15, 1'b0, cnt);
    check("R1 acc cleared, first tick", cnt, 0);

    repeat (3) @(negedge clk);
    report();
  end
endmodule